// File: doc/BRIEF.md
# Duty-Cycle Address Gate with Word Budget

This block throttles a memory port by opening and closing its address channel on a repeating schedule. A period is made of an open window followed by a closed window, each a programmable number of timer ticks. While the open window runs, address handshakes pass unchanged. While the closed window runs, they are held off. Data beats are never held back, so a burst whose address was already accepted can finish during the closed window.

On top of the schedule, a per-period budget counts the 64-bit data beats that complete. When the count reaches the programmed budget, the address channel closes for the rest of the period. A budget of zero removes the limit. A frequency scale divides the timer tick so that the whole schedule stretches. This emulates a slower bus without changing the clock.

The gate sits in line with the address valid/ready pair. It uses the data valid/ready pair only to observe completed beats.

Top module: `duty_addr_gate`

## Requirements
- R1: `addr_valid_o` equals `addr_valid_i` AND `addr_gate_o`, and `addr_ready_o` equals `addr_ready_i` AND `addr_gate_o`, in the same cycle with no register in the path.
- R2: With scale 0 and budget 0, `addr_gate_o` is high for exactly `cfg_on_len_i` consecutive cycles and then low for exactly `cfg_off_len_i` cycles, repeating. With an open window of 4000, a closed window of 1000 and a budget of 0, this gives 8000 open cycles in 10000.
- R3: With a nonzero budget, once the number of completed beats (`beat_valid_i` AND `beat_ready_i` at a clock edge) in the current period reaches `cfg_word_cap_i`, `addr_gate_o` stays low until the next period starts. A budget at or above the open window length has no effect.
- R4: A budget of 0 places no limit on the number of beats.
- R5: The beat count restarts from zero at every period start. A beat that completes at the edge that ends a period counts toward the ending period, not the new one. With 4000/1000 and a budget of 1172 under a continuous beat stream, every period opens for exactly 1172 cycles.
- R6: With `cfg_on_len_i` = 0, `addr_gate_o` never goes high. This also holds when both window lengths are 0.
- R7: With `cfg_off_len_i` = 0, the window never closes, but the budget still applies and its count restarts every `cfg_on_len_i` ticks.
- R8: With `cfg_freq_scale_i` = N, the schedule advances once every N+1 clock cycles, so each window lasts N+1 times as many cycles. N = 255 gives 1/256 speed.
- R9: After reset the period starts at its first open tick with a beat count of zero. `on_window_o` reports the schedule's open window whether or not the budget is exhausted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_on_len_i | input | 16 | Open window length in ticks |
| cfg_off_len_i | input | 16 | Closed window length in ticks |
| cfg_word_cap_i | input | 16 | Beat budget per period, 0 = unlimited |
| cfg_freq_scale_i | input | 8 | Tick divider minus one, 0 = every cycle |
| addr_valid_i | input | 1 | Upstream address valid |
| addr_ready_i | input | 1 | Downstream address ready |
| beat_valid_i | input | 1 | Data beat valid (observed only) |
| beat_ready_i | input | 1 | Data beat ready (observed only) |
| addr_valid_o | output | 1 | Gated address valid to downstream |
| addr_ready_o | output | 1 | Gated address ready to upstream |
| addr_gate_o | output | 1 | Address channel currently open |
| on_window_o | output | 1 | Schedule is in its open window |

## Verification
The bench first checks the scale-0 schedule. A timer that is off by one would open for `cfg_on_len_i`±1 cycles, and the 4000/1000 run would no longer count exactly 8000 open cycles. Budget runs with a continuous beat stream check that every period opens for exactly the budget. A design that counted the beat at the period-ending edge toward the new period would open one cycle short from the second period on. A design that never cleared its count would close for good after the first period. The degenerate settings are checked separately: a zero open window, both windows zero, and a zero closed window. A design that mishandled a zero-length period could wrap its counter or leave the gate stuck open. The two scale runs check that windows stretch by N+1 and not by N.

// File: rtl/duty_gate_pkg.sv
package duty_gate_pkg;
  localparam int unsigned LEN_W_DEF   = 16;
  localparam int unsigned WORD_W_DEF  = 16;
  localparam int unsigned SCALE_W_DEF = 8;

  typedef enum logic [1:0] {
    GATE_OPEN   = 2'b01,
    GATE_SHUT   = 2'b10,
    GATE_BUDGET = 2'b11
  } gate_state_e;
endpackage

// File: rtl/duty_tick_gen.sv
module duty_tick_gen #(
  parameter int unsigned SCALE_W = duty_gate_pkg::SCALE_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               tick_o
);
  logic [SCALE_W-1:0] div_q;

  // >= rather than == so a lowered scale never strands the divider
  assign tick_o = (div_q >= scale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (scale_i != '0) |=> !tick_o || (scale_i == '0)); // R8
endmodule

// File: rtl/duty_timer.sv
module duty_timer #(
  parameter int unsigned LEN_W = duty_gate_pkg::LEN_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] on_len_i,
  input  logic [LEN_W-1:0] off_len_i,
  output logic             win_o,
  output logic             wrap_o
);
  localparam int unsigned POS_W = LEN_W + 1;

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] period;
  logic [POS_W-1:0] pos_inc;
  logic             last_tick;

  assign period    = POS_W'(on_len_i) + POS_W'(off_len_i);
  assign pos_inc   = pos_q + 1'b1;
  // >= covers a zero period and a period shortened on the fly
  assign last_tick = (pos_inc >= period);
  assign wrap_o    = tick_i && last_tick;
  assign win_o     = (pos_q < POS_W'(on_len_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (wrap_o)  pos_q <= '0;
    else if (tick_i)  pos_q <= pos_inc;
  end

  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pos_q)); // R8
endmodule

// File: rtl/duty_word_budget.sv
module duty_word_budget #(
  parameter int unsigned WORD_W = duty_gate_pkg::WORD_W_DEF,
  parameter bit          CAP_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              beat_i,
  input  logic [WORD_W-1:0] cap_i,
  output logic              spent_o
);
  generate
    if (CAP_EN) begin : g_cap
      logic [WORD_W-1:0] words_q;
      logic              sat;

      assign sat     = &words_q;
      assign spent_o = (cap_i != '0) && (words_q >= cap_i);

      // a beat on the clearing edge belongs to the period that ends
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              words_q <= '0;
        else if (clear_i)         words_q <= '0;
        else if (beat_i && !sat)  words_q <= words_q + 1'b1;
      end

      AST_WORD_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> words_q >= $past(words_q)); // R5
    end else begin : g_nocap
      assign spent_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/duty_addr_gate.sv
module duty_addr_gate #(
  parameter int unsigned LEN_W   = duty_gate_pkg::LEN_W_DEF,
  parameter int unsigned WORD_W  = duty_gate_pkg::WORD_W_DEF,
  parameter int unsigned SCALE_W = duty_gate_pkg::SCALE_W_DEF,
  parameter bit          CAP_EN  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LEN_W-1:0]   cfg_on_len_i,
  input  logic [LEN_W-1:0]   cfg_off_len_i,
  input  logic [WORD_W-1:0]  cfg_word_cap_i,
  input  logic [SCALE_W-1:0] cfg_freq_scale_i,
  input  logic               addr_valid_i,
  input  logic               addr_ready_i,
  input  logic               beat_valid_i,
  input  logic               beat_ready_i,
  output logic               addr_valid_o,
  output logic               addr_ready_o,
  output logic               addr_gate_o,
  output logic               on_window_o
);
  import duty_gate_pkg::*;

  logic        tick;
  logic        win;
  logic        wrap;
  logic        spent;
  gate_state_e state;

  duty_tick_gen #(.SCALE_W(SCALE_W)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scale_i (cfg_freq_scale_i),
    .tick_o  (tick)
  );

  duty_timer #(.LEN_W(LEN_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .on_len_i  (cfg_on_len_i),
    .off_len_i (cfg_off_len_i),
    .win_o     (win),
    .wrap_o    (wrap)
  );

  duty_word_budget #(.WORD_W(WORD_W), .CAP_EN(CAP_EN)) u_budget (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (wrap),
    .beat_i  (beat_valid_i && beat_ready_i),
    .cap_i   (cfg_word_cap_i),
    .spent_o (spent)
  );

  always_comb begin
    if (!win)       state = GATE_SHUT;
    else if (spent) state = GATE_BUDGET;
    else            state = GATE_OPEN;
  end

  assign addr_gate_o  = (state == GATE_OPEN);
  assign on_window_o  = win;
  assign addr_valid_o = addr_valid_i && addr_gate_o;
  assign addr_ready_o = addr_ready_i && addr_gate_o;

  AST_PASS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> addr_valid_i && on_window_o); // R1
  AST_ZERO_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_on_len_i == '0) |-> !addr_gate_o); // R6
  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spent && !wrap |=> !addr_gate_o || !$stable(cfg_word_cap_i)); // R3
endmodule

// File: tb/duty_addr_gate_bench.sv
module duty_addr_gate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] on_len = '0, off_len = '0, cap = '0;
  logic [7:0]  scale = '0;
  logic        av_i = 1'b0, ar_i = 1'b0, bv_i = 1'b0, br_i = 1'b0;
  logic        av_o, ar_o, gate_o, win_o;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  duty_addr_gate u_duty_addr_gate (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_on_len_i(on_len), .cfg_off_len_i(off_len),
    .cfg_word_cap_i(cap), .cfg_freq_scale_i(scale),
    .addr_valid_i(av_i), .addr_ready_i(ar_i),
    .beat_valid_i(bv_i), .beat_ready_i(br_i),
    .addr_valid_o(av_o), .addr_ready_o(ar_o),
    .addr_gate_o(gate_o), .on_window_o(win_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int on_v, input int off_v, input int cap_v,
                          input int sc_v, input bit beats);
    @(negedge clk);
    rst_ni = 1'b0;
    on_len = 16'(on_v); off_len = 16'(off_v); cap = 16'(cap_v); scale = 8'(sc_v);
    bv_i = beats; br_i = beats;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // reference schedule built from the requirements; sampled between edges
  task automatic run_case(input string req, input int on_v, input int off_v,
                          input int cap_v, input int sc_v, input bit beats,
                          input int ncyc, input int exp_open, input int exp_win);
    int pos = 0, div = 0, words = 0, period;
    int bad = 0, bad_pass = 0, opens = 0, wins = 0;
    bit e_win, e_gate, tk;
    period = on_v + off_v;
    do_reset(on_v, off_v, cap_v, sc_v, beats);
    for (int k = 0; k < ncyc; k++) begin
      av_i = k[0]; ar_i = k[1];
      #1;
      e_win  = (pos < on_v);
      e_gate = e_win && (cap_v == 0 || words < cap_v);
      if (gate_o !== e_gate || win_o !== e_win) bad++;
      if (av_o !== (av_i & e_gate) || ar_o !== (ar_i & e_gate)) bad_pass++;
      if (gate_o === 1'b1) opens++;
      if (win_o === 1'b1) wins++;
      tk = (div >= sc_v);
      div = tk ? 0 : div + 1;
      if (tk && pos + 1 >= period) begin
        pos = 0; words = 0;
      end else begin
        if (tk) pos++;
        if (beats && words < 65535) words++;
      end
      @(negedge clk);
    end
    check({req, " cycle pattern mismatches"}, bad, 0);
    check({"R1 pass-through mismatches in ", req}, bad_pass, 0);
    check({req, " open cycles"}, opens, exp_open);
    check({req, " window cycles"}, wins, exp_win);
  endtask

  task automatic t_reset_state();
    do_reset(5, 3, 0, 0, 1'b0);
    av_i = 1'b0; ar_i = 1'b1;
    #1;
    check("R9 gate open right after reset", int'(gate_o), 1);
    check("R9 window open right after reset", int'(win_o), 1);
    check("R1 ready passes with valid low", int'(ar_o), 1);
    check("R1 valid low stays low", int'(av_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    run_case("R2 4000/1000 schedule", 4000, 1000, 0, 0, 1'b0, 10000, 8000, 8000);
    run_case("R5 4000/1000 budget 1172", 4000, 1000, 1172, 0, 1'b1, 10000, 2344, 8000);
    run_case("R3 budget above window", 20, 10, 50, 0, 1'b1, 90, 60, 60);
    run_case("R4 zero budget unlimited", 20, 10, 0, 0, 1'b1, 90, 60, 60);
    run_case("R5 budget restarts", 6, 4, 4, 0, 1'b1, 30, 12, 18);
    run_case("R6 zero open window", 0, 5, 0, 0, 1'b0, 50, 0, 0);
    run_case("R6 both windows zero", 0, 0, 0, 0, 1'b1, 20, 0, 0);
    run_case("R7 zero closed window budget", 7, 0, 3, 0, 1'b1, 70, 30, 70);
    run_case("R7 zero closed window free", 7, 0, 0, 0, 1'b1, 70, 70, 70);
    run_case("R8 scale 3", 3, 2, 0, 3, 1'b0, 60, 36, 36);
    run_case("R8 scale 255", 1, 1, 0, 255, 1'b0, 1024, 512, 512);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule